// File: doc/BRIEF.md
# Receive Address Filter

This block sits on the receive side of an Ethernet MAC and decides, from the first six bytes of each frame, whether the frame is kept or dropped. Bytes arrive one per cycle on `rx_byte` when `rx_vld` is high. `rx_sof` is raised together with `rx_vld` on the first destination byte. As the six destination bytes arrive, the block gathers them into a 48-bit address. At the same time it folds them into a CRC-32 register. The cycle after the sixth byte is taken, it raises `dec_valid` for one cycle with the verdict on `dec_accept`.

The verdict is built from four paths:
- **Exact match.** A unicast address must equal the programmed station address.
- **Broadcast.** The all-ones address is taken or refused under the `bcast_reject` control.
- **Multicast hash.** A multicast address looks up one bit of a 64-bin table, indexed by the upper six CRC bits.
- **Promiscuous.** The `promisc` control overrides everything.

The control is a three-state machine:
- `ST_IDLE`: waiting for a frame start.
- `ST_COLLECT`: destination bytes two to six are being taken.
- `ST_DECIDE`: the one-cycle verdict.

The transitions are:
- IDLE→COLLECT on a start byte.
- COLLECT→COLLECT on a start byte (restart) or on an ordinary byte before the sixth.
- COLLECT→DECIDE on the sixth byte.
- DECIDE→COLLECT on a start byte.
- DECIDE→IDLE otherwise.

Top module: `rx_addr_filter`

## Requirements
- R1: After reset, `dec_valid` and `dec_accept` are both 0, and they stay 0 until a full destination address has been received.
- R2: The byte presented with `rx_sof`=1 and `rx_vld`=1 is destination byte 0. Later bytes count only in cycles with `rx_vld`=1; idle cycles between bytes are allowed. `dec_valid` is 1 in exactly the one cycle that follows the clock edge which took byte 5.
- R3: The station address is given as follows. `sta_hi[15:8]` is byte 0 and `sta_hi[7:0]` is byte 1. `sta_lo[31:24]` is byte 2, `sta_lo[23:16]` byte 3, `sta_lo[15:8]` byte 4 and `sta_lo[7:0]` byte 5. A unicast address (bit 0 of byte 0 clear) is accepted only if all 48 bits equal the station address.
- R4: The address FF:FF:FF:FF:FF:FF is accepted when `bcast_reject`=0 and rejected when `bcast_reject`=1. This holds regardless of the hash table.
- R5: When `promisc`=1, every decision is an accept.
- R6: A multicast address has bit 0 of byte 0 set and is not the broadcast address. For such an address, a CRC-32 is computed over the six bytes in arrival order. The CRC uses polynomial 0x04C11DB7 and starts from all ones. Each byte is fed least significant bit first, and the result is not inverted. CRC bits 31:26 form an index. Index bit 5 selects `hash_hi` (1) or `hash_lo` (0), and index bits 4:0 select the bit within that word. The frame is accepted exactly when that bit is 1.
- R7: With both hash words all ones, every multicast address is accepted. With both hash words zero, a multicast address is rejected even when it equals the station address.
- R8: A start byte that arrives while an address is partly collected discards the partial bytes and begins a new address; no decision is given for the abandoned one.
- R9: Bytes after the sixth destination byte, up to the next start byte, produce no further decision.
- R10: `dec_accept` is 0 in every cycle in which `dec_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_sof | input | 1 | Marks destination byte 0, qualified by `rx_vld` |
| rx_vld | input | 1 | `rx_byte` carries a frame byte this cycle |
| rx_byte | input | 8 | Received byte |
| sta_lo | input | 32 | Station address bytes 2..5 |
| sta_hi | input | 16 | Station address bytes 0..1 |
| hash_lo | input | 32 | Multicast bins 0..31 |
| hash_hi | input | 32 | Multicast bins 32..63 |
| bcast_reject | input | 1 | Refuse the broadcast address |
| promisc | input | 1 | Accept every frame |
| dec_valid | output | 1 | One-cycle decision strobe |
| dec_accept | output | 1 | Decision, meaningful with `dec_valid` |

## Verification
The decision is due exactly one clock after the edge that takes the sixth valid byte, whatever idle gaps came before it. The bench drives each byte on a falling edge and lets one rising edge capture it. It then reads `dec_valid` and `dec_accept` on the falling edge after the sixth byte, and reads them once more on the next falling edge to confirm that the strobe has dropped. For restarts and for trailing bytes, the outputs are sampled on every falling edge of the stimulus, so any stray strobe is seen in the cycle it appears. Expected verdicts come from a bench model built from the requirements, including its own CRC. Multicast bins are swept by driving each address's own bin alone, and then every bin except that one.

// File: rtl/af_pkg.sv
package af_pkg;
    localparam int BYTE_W   = 8;
    localparam int DA_BYTES = 6;
    localparam int DA_BITS  = DA_BYTES * BYTE_W;
    localparam int LO_BITS  = 32;
    localparam int HI_BITS  = DA_BITS - LO_BITS;
    localparam int CNT_W    = $clog2(DA_BYTES);
    localparam int CRC_W    = 32;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_COLLECT = 2'd1,
        ST_DECIDE  = 2'd2
    } af_state_e;

    typedef struct packed {
        logic is_bcast;
        logic is_mcast;
        logic is_ucast;
    } af_class_t;
endpackage

// File: rtl/af_crc_step.sv
module af_crc_step
    import af_pkg::*;
#(
    parameter logic [CRC_W-1:0] POLY = 32'h04C11DB7
) (
    input  logic [CRC_W-1:0]  crc_in,
    input  logic [BYTE_W-1:0] data_in,
    output logic [CRC_W-1:0]  crc_out
);
    always_comb begin
        logic [CRC_W-1:0] c;
        c = crc_in;
        for (int i = 0; i < BYTE_W; i++) begin
            if (c[CRC_W-1] ^ data_in[i])
                c = {c[CRC_W-2:0], 1'b0} ^ POLY;
            else
                c = {c[CRC_W-2:0], 1'b0};
        end
        crc_out = c;
    end
endmodule

// File: rtl/af_collector.sv
module af_collector
    import af_pkg::*;
#(
    parameter logic [CRC_W-1:0] POLY = 32'h04C11DB7,
    parameter logic [CRC_W-1:0] INIT = 32'hFFFFFFFF
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sof_i,
    input  logic               vld_i,
    input  logic [BYTE_W-1:0]  byte_i,
    output logic [DA_BITS-1:0] addr_o,
    output logic [CRC_W-1:0]   crc_o,
    output logic               decide_o
);
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(DA_BYTES - 1);

    af_state_e         state_q, state_nx;
    logic [CNT_W-1:0]  cnt_q;
    logic [DA_BITS-1:0] addr_q;
    logic [CRC_W-1:0]  crc_q, crc_seed, crc_next;
    logic              start, take_more, last_byte;

    assign start     = vld_i & sof_i;
    assign take_more = (state_q == ST_COLLECT) & vld_i & ~sof_i;
    assign last_byte = take_more & (cnt_q == LAST_CNT);
    assign crc_seed  = start ? INIT : crc_q;

    af_crc_step #(.POLY(POLY)) u_crc (
        .crc_in  (crc_seed),
        .data_in (byte_i),
        .crc_out (crc_next)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_nx;
    end

    // next-state logic
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_IDLE:    if (start) state_nx = ST_COLLECT;
            ST_COLLECT: begin
                if (start)          state_nx = ST_COLLECT;
                else if (last_byte) state_nx = ST_DECIDE;
            end
            ST_DECIDE:  state_nx = start ? ST_COLLECT : ST_IDLE;
            default:    state_nx = ST_IDLE;
        endcase
    end

    // address and CRC accumulation
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            addr_q <= '0;
            crc_q  <= INIT;
        end else if (start) begin
            cnt_q  <= CNT_W'(1);
            addr_q <= {{(DA_BITS-BYTE_W){1'b0}}, byte_i};
            crc_q  <= crc_next;
        end else if (take_more) begin
            cnt_q  <= cnt_q + CNT_W'(1);
            addr_q <= {addr_q[DA_BITS-BYTE_W-1:0], byte_i};
            crc_q  <= crc_next;
        end
    end

    // outputs
    always_comb begin
        decide_o = (state_q == ST_DECIDE);
        addr_o   = addr_q;
        crc_o    = crc_q;
    end

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_COLLECT) |-> (cnt_q >= CNT_W'(1) && cnt_q <= LAST_CNT)); // R2
    AST_DECIDE_AFTER_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DECIDE) |-> $past(vld_i)); // R2
    AST_DECIDE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DECIDE) |=> (state_q != ST_DECIDE)); // R9
    AST_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (state_q == ST_COLLECT)); // R8
endmodule

// File: rtl/af_decide.sv
module af_decide
    import af_pkg::*;
#(
    parameter int HASH_BITS = 6,
    localparam int HASH_HALF = 2 ** (HASH_BITS - 1)
) (
    input  logic [DA_BITS-1:0]   addr_i,
    input  logic [HASH_BITS-1:0] idx_i,
    input  logic [LO_BITS-1:0]   sta_lo_i,
    input  logic [HI_BITS-1:0]   sta_hi_i,
    input  logic [HASH_HALF-1:0] hash_lo_i,
    input  logic [HASH_HALF-1:0] hash_hi_i,
    input  logic                 bcast_reject_i,
    input  logic                 promisc_i,
    output af_class_t            class_o,
    output logic                 accept_o
);
    // bit 0 of byte 0 is the group bit; byte 0 sits at the top of addr_i
    localparam int GROUP_BIT = DA_BITS - BYTE_W;

    logic [2*HASH_HALF-1:0] table_w;
    logic                   hash_hit, exact_hit;

    always_comb begin
        table_w            = {hash_hi_i, hash_lo_i};
        hash_hit           = table_w[idx_i];
        exact_hit          = (addr_i == {sta_hi_i, sta_lo_i});
        class_o.is_bcast   = &addr_i;
        class_o.is_mcast   = addr_i[GROUP_BIT] & ~class_o.is_bcast;
        class_o.is_ucast   = ~addr_i[GROUP_BIT];
        accept_o = promisc_i
                 | (class_o.is_bcast & ~bcast_reject_i)
                 | (class_o.is_mcast & hash_hit)
                 | (class_o.is_ucast & exact_hit);
    end
endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter
    import af_pkg::*;
#(
    parameter logic [31:0] CRC_POLY  = 32'h04C11DB7,
    parameter logic [31:0] CRC_INIT  = 32'hFFFFFFFF,
    parameter int          HASH_BITS = 6,
    localparam int         HASH_HALF = 2 ** (HASH_BITS - 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rx_sof,
    input  logic                 rx_vld,
    input  logic [7:0]           rx_byte,
    input  logic [31:0]          sta_lo,
    input  logic [15:0]          sta_hi,
    input  logic [HASH_HALF-1:0] hash_lo,
    input  logic [HASH_HALF-1:0] hash_hi,
    input  logic                 bcast_reject,
    input  logic                 promisc,
    output logic                 dec_valid,
    output logic                 dec_accept
);
    logic [DA_BITS-1:0] addr_w;
    logic [CRC_W-1:0]   crc_w;
    logic               decide_w, accept_w;
    af_class_t          class_w;

    af_collector #(.POLY(CRC_POLY), .INIT(CRC_INIT)) u_collect (
        .clk      (clk),
        .rst_n    (rst_n),
        .sof_i    (rx_sof),
        .vld_i    (rx_vld),
        .byte_i   (rx_byte),
        .addr_o   (addr_w),
        .crc_o    (crc_w),
        .decide_o (decide_w)
    );

    af_decide #(.HASH_BITS(HASH_BITS)) u_decide (
        .addr_i         (addr_w),
        .idx_i          (crc_w[CRC_W-1 -: HASH_BITS]),
        .sta_lo_i       (sta_lo),
        .sta_hi_i       (sta_hi),
        .hash_lo_i      (hash_lo),
        .hash_hi_i      (hash_hi),
        .bcast_reject_i (bcast_reject),
        .promisc_i      (promisc),
        .class_o        (class_w),
        .accept_o       (accept_w)
    );

    always_comb begin
        dec_valid  = decide_w;
        dec_accept = decide_w & accept_w;
    end

    AST_ACCEPT_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
        dec_accept |-> dec_valid); // R10
    AST_PROMISC_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && promisc) |-> dec_accept); // R5
    AST_BCAST_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && (&addr_w) && bcast_reject && !promisc) |-> !dec_accept); // R4
    AST_UCAST_MISMATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && class_w.is_ucast && !promisc && addr_w != {sta_hi, sta_lo})
        |-> !dec_accept); // R3
    AST_NO_BACK_TO_BACK: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |=> !dec_valid); // R2
endmodule

// File: tb/rx_addr_filter_bench.sv
module rx_addr_filter_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_sof = 1'b0, rx_vld = 1'b0;
    logic [7:0]  rx_byte = '0;
    logic [31:0] sta_lo = '0, hash_lo = '0, hash_hi = '0;
    logic [15:0] sta_hi = '0;
    logic        bcast_reject = 1'b0, promisc = 1'b0;
    logic        dec_valid, dec_accept;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rx_addr_filter u_rx_addr_filter (
        .clk(clk), .rst_n(rst_n), .rx_sof(rx_sof), .rx_vld(rx_vld),
        .rx_byte(rx_byte), .sta_lo(sta_lo), .sta_hi(sta_hi),
        .hash_lo(hash_lo), .hash_hi(hash_hi), .bcast_reject(bcast_reject),
        .promisc(promisc), .dec_valid(dec_valid), .dec_accept(dec_accept)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // CRC as defined in R6
    function automatic logic [31:0] ref_crc(input logic [47:0] a);
        logic [31:0] c = 32'hFFFFFFFF;
        for (int b = 0; b < 6; b++) begin
            logic [7:0] d = a[47-8*b -: 8];
            for (int i = 0; i < 8; i++) begin
                logic fb = c[31] ^ d[i];
                c = {c[30:0], 1'b0};
                if (fb) c = c ^ 32'h04C11DB7;
            end
        end
        return c;
    endfunction

    function automatic int ref_idx(input logic [47:0] a);
        logic [31:0] c = ref_crc(a);
        return int'(c[31:26]);
    endfunction

    function automatic logic ref_accept(input logic [47:0] a);
        logic bc = (a == 48'hFFFF_FFFF_FFFF);
        logic mc = a[40] && !bc;
        int   ix = ref_idx(a);
        logic hv = (ix >= 32) ? hash_hi[ix-32] : hash_lo[ix];
        return promisc || (bc && !bcast_reject) || (mc && hv)
            || (!a[40] && a == {sta_hi, sta_lo});
    endfunction

    task automatic send_da(input logic [47:0] a, input int gap);
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            rx_sof = (i == 0); rx_vld = 1'b1; rx_byte = a[47-8*i -: 8];
            for (int g = 0; g < gap && i < 5; g++) begin
                @(negedge clk);
                rx_sof = 1'b0; rx_vld = 1'b0; rx_byte = 8'h5A;
            end
        end
        @(negedge clk);
        rx_sof = 1'b0; rx_vld = 1'b0;
    endtask

    task automatic expect_dec(input string req, input logic exp);
        chk({req, " dec_valid"}, 32'(dec_valid), 32'd1);
        chk({req, " dec_accept"}, 32'(dec_accept), 32'(exp));
        @(negedge clk);
        chk({req, " R2 strobe width"}, 32'(dec_valid), 32'd0);
        chk({req, " R10 accept idle"}, 32'(dec_accept), 32'd0);
    endtask

    task automatic frame(input string req, input logic [47:0] a, input int gap);
        send_da(a, gap);
        expect_dec(req, ref_accept(a));
    endtask

    function automatic logic [47:0] rnd48();
        return {16'($urandom), $urandom};
    endfunction

    initial begin
        repeat (CLK_PERIOD * 20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R2 watchdog actual=hung expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [47:0] sta, a;
        repeat (3) @(negedge clk);
        chk("R1 reset valid", 32'(dec_valid), 32'd0);
        chk("R1 reset accept", 32'(dec_accept), 32'd0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 idle valid", 32'(dec_valid), 32'd0);

        // R3 exact match and every single-bit mismatch
        sta = rnd48(); sta[40] = 1'b0;
        {sta_hi, sta_lo} = sta;
        frame("R3 exact", sta, 0);
        chk("R3 exact accepted", 32'(ref_accept(sta)), 32'd1);
        for (int b = 0; b < 48; b++) frame("R3 bit flip", sta ^ (48'd1 << b), 0);
        {sta_hi, sta_lo} = {16'h0211, 32'h2233_4455};
        send_da(48'h0211_2233_4455, 0);
        expect_dec("R3 field mapping", 1'b1);
        send_da(48'h0211_2233_4456, 0);
        expect_dec("R3 field mapping miss", 1'b0);

        // R2 gaps between bytes
        send_da(48'h0211_2233_4455, 2);
        expect_dec("R2 gapped bytes", 1'b1);

        // R4 broadcast
        bcast_reject = 1'b0; hash_lo = '1; hash_hi = '1;
        send_da(48'hFFFF_FFFF_FFFF, 0); expect_dec("R4 bcast allowed", 1'b1);
        bcast_reject = 1'b1;
        send_da(48'hFFFF_FFFF_FFFF, 0); expect_dec("R4 bcast refused", 1'b0);
        hash_lo = '0; hash_hi = '0;
        bcast_reject = 1'b0;
        send_da(48'hFFFF_FFFF_FFFF, 1); expect_dec("R4 bcast empty hash", 1'b1);

        // R5 promiscuous
        promisc = 1'b1; bcast_reject = 1'b1;
        for (int k = 0; k < 8; k++) begin
            send_da(rnd48(), k % 2); expect_dec("R5 promisc", 1'b1);
        end
        send_da(48'hFFFF_FFFF_FFFF, 0); expect_dec("R5 promisc bcast", 1'b1);
        promisc = 1'b0;

        // R6 hash bin sweep
        for (int k = 0; k < 40; k++) begin
            int ix;
            a = rnd48(); a[40] = 1'b1;
            if (a == 48'hFFFF_FFFF_FFFF) a[0] = 1'b0;
            ix = ref_idx(a);
            {hash_hi, hash_lo} = 64'd1 << ix;
            send_da(a, 0); expect_dec("R6 own bin set", 1'b1);
            {hash_hi, hash_lo} = ~(64'd1 << ix);
            send_da(a, 0); expect_dec("R6 own bin clear", 1'b0);
        end

        // R7 all-ones table, and multicast never via station compare
        hash_lo = '1; hash_hi = '1;
        for (int k = 0; k < 6; k++) begin
            a = rnd48(); a[40] = 1'b1; a[1] = 1'b0;
            send_da(a, 0); expect_dec("R7 all bins", 1'b1);
        end
        hash_lo = '0; hash_hi = '0;
        a = 48'h0100_5E00_0001;
        {sta_hi, sta_lo} = a;
        send_da(a, 0); expect_dec("R7 mcast equals station", 1'b0);

        // R8 restart mid-address
        {sta_hi, sta_lo} = 48'h0A0B_0C0D_0E0F;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            rx_sof = (i == 0); rx_vld = 1'b1; rx_byte = 8'hEE;
        end
        @(negedge clk);
        chk("R8 no partial decision", 32'(dec_valid), 32'd0);
        rx_vld = 1'b0; rx_sof = 1'b0;
        send_da(48'h0A0B_0C0D_0E0F, 0);
        expect_dec("R8 restarted address", 1'b1);

        // R9 trailing bytes ignored
        send_da(48'h0A0B_0C0D_0E0F, 0);
        expect_dec("R9 head", 1'b1);
        for (int i = 0; i < 12; i++) begin
            rx_vld = 1'b1; rx_sof = 1'b0; rx_byte = 8'(i);
            @(negedge clk);
            chk("R9 no extra decision", 32'(dec_valid), 32'd0);
            chk("R10 accept low", 32'(dec_accept), 32'd0);
        end
        rx_vld = 1'b0;
        repeat (2) @(negedge clk);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule